// File: doc/BRIEF.md
# Softmax Denominator Accumulator and Score Normalizer

This block is the back half of a hardware softmax stage. Upstream logic turns each class logit of a region proposal into a non-negative fixed-point exponential and streams those values in, one per handshake. The block keeps every value in a small register file while adding it into a denominator that is wide enough never to wrap. Once the vector closes, it walks the stored values in arrival order and sends one normalized score per class. Each score is a pure fraction of `OUT_W` bits.

Two ways of dividing are offered, and the mode is picked per vector. Exact mode runs a restoring divider that yields one quotient bit per clock. Shift mode rounds the denominator to its nearest power of two and right-shifts each numerator instead. Each proposal is handled on its own: a new vector is taken only after the last score of the previous one has left the block.

Numerators and the denominator share the same fixed-point scale, so a score is the integer ratio `num * 2^OUT_W / den`. A score that would reach 1.0 is clamped to the largest fraction.

Top module: `softnorm_seq`

## Requirements
- R1: While collecting, `in_ready` is high and each `in_valid && in_ready` handshake stores one element. An element whose top bit (the sign, bit `EXP_W-1`) is 1 is stored as zero. A vector closes on the handshake that carries `in_last` or on its `NCLS`-th element, whichever comes first. Exactly as many scores are sent as elements were taken, and `out_last` is high only on the final one.
- R2: In exact mode (`div_mode`=0) a score equals min(2^OUT_W-1, floor(num*2^OUT_W/den)).
- R3: In shift mode (`div_mode`=1) let p be the leading-one position of den. Then n = p+1 if bit p-1 of den is 1, and n = p otherwise. A score equals min(2^OUT_W-1, floor(num*2^OUT_W/2^n)). So a denominator that is exactly 2^k uses n=k, and one halfway between 2^k and 2^(k+1) uses n=k+1.
- R4: If the denominator of a vector is zero, every score of that vector is 0 in either mode.
- R5: `div_mode` is sampled on the handshake that closes a vector. Changes to it while that vector's scores are being sent have no effect on them.
- R6: From the closing handshake until the handshake of the last score, `in_ready` is low, so no input is taken. `in_ready` and `out_valid` are never high together.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_score` and `out_last` hold their values.
- R8: With `out_ready` held high, successive scores of a vector appear OUT_W+4 cycles apart in exact mode. In shift mode, or when the denominator is zero, they appear 2 cycles apart.
- R9: After reset, `in_ready` is 1 and `out_valid` is 0.
- R10: The denominator is EXP_W-1+ceil(log2 NCLS)+1 bits wide. A full vector of the largest inputs gives correct scores without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Exponential element valid |
| in_ready | output | 1 | Block can take an element |
| in_exp | input | EXP_W | Exponential; top bit is the sign, LSB is the fraction |
| in_last | input | 1 | Element closes the vector |
| div_mode | input | 1 | 0 = exact divide, 1 = power-of-two shift |
| out_valid | output | 1 | Score valid |
| out_ready | input | 1 | Downstream takes the score |
| out_score | output | OUT_W | Normalized score, all fraction bits |
| out_last | output | 1 | Final score of the vector |

## Verification
The same random 21-element vector is run in both modes. Scores that agree in one mode and differ in the other show that the rounding to a power of two and the restoring quotient are each correct. Hand-built denominators test the rounding edges: an exact power of two, a value halfway between two powers, a single element whose exact ratio clamps, and a zero sum. Sign-bit inputs and short vectors closed by the last flag test clamping and element counting. Random backpressure, a mode flip while scores are being sent, and inputs held valid during the output phase show that the output holds, that the mode is sampled once, and that inputs are locked out.

// File: rtl/softnorm_pkg.sv
package softnorm_pkg;
    typedef enum logic [1:0] {
        PH_LOAD  = 2'd0,
        PH_START = 2'd1,
        PH_WAIT  = 2'd2,
        PH_SEND  = 2'd3
    } phase_t;
endpackage

// File: rtl/softnorm_regfile.sv
module softnorm_regfile #(
    parameter int DEPTH = 21,
    parameter int W     = 10,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q[g] <= '0;
            else if (we && (waddr == AW'(g)))
                cell_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (raddr == AW'(i)) rdata = cell_q[i];
    end
endmodule

// File: rtl/softnorm_nearp2.sv
module softnorm_nearp2 #(
    parameter int DEN_W = 16,
    parameter int SH_W  = 5
) (
    input  logic [DEN_W-1:0] den,
    output logic [SH_W-1:0]  sh_n
);
    logic [SH_W-1:0] lead;
    logic            below;

    always_comb begin
        lead  = '0;
        below = 1'b0;
        for (int i = 1; i < DEN_W; i++) begin
            if (den[i]) begin
                lead  = SH_W'(i);
                below = den[i-1];
            end
        end
        sh_n = below ? lead + SH_W'(1) : lead;
    end
endmodule

// File: rtl/softnorm_rdiv.sv
module softnorm_rdiv #(
    parameter int NUM_W = 10,
    parameter int DEN_W = 16,
    parameter int Q_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quot
);
    localparam int R_W  = DEN_W + 1;
    localparam int ST_W = $clog2(Q_W + 1);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [ST_W-1:0] steps;
        logic [R_W-1:0]  rem;
        logic [DEN_W-1:0] dvs;
        logic [Q_W-1:0]  q;
    } div_t;

    div_t st_d, st_q;
    logic [R_W-1:0] diff;
    logic           fits;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        fits      = st_q.rem >= R_W'(st_q.dvs);
        diff      = fits ? st_q.rem - R_W'(st_q.dvs) : st_q.rem;
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.steps = '0;
            st_d.rem   = R_W'(num);
            st_d.dvs   = den;
            st_d.q     = '0;
        end else if (st_q.busy) begin
            st_d.q     = {st_q.q[Q_W-2:0], fits};
            st_d.rem   = diff << 1;
            st_d.steps = st_q.steps + ST_W'(1);
            if (st_q.steps == ST_W'(Q_W - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign quot = st_q.q;

    // R8: a result is flagged only after a busy cycle
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.busy));
endmodule

// File: rtl/softnorm_seq.sv
module softnorm_seq #(
    parameter int NCLS  = 21,
    parameter int EXP_W = 11,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [EXP_W-1:0] in_exp,
    input  logic             in_last,
    input  logic             div_mode,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_score,
    output logic             out_last
);
    import softnorm_pkg::*;

    localparam int MAG_W  = EXP_W - 1;
    localparam int CNT_W  = $clog2(NCLS + 1);
    localparam int DEN_W  = EXP_W + $clog2(NCLS);
    localparam int SH_W   = $clog2(DEN_W + 1);
    localparam int WIDE_W = MAG_W + OUT_W;
    localparam int Q_W    = OUT_W + 1;

    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] idx;
        logic [DEN_W-1:0] den;
        logic             mode;
        logic [OUT_W-1:0] score;
    } seq_t;

    seq_t st_d, st_q;

    logic             wr_en;
    logic [MAG_W-1:0] wr_val;
    logic [MAG_W-1:0] rd_num;
    logic [SH_W-1:0]  sh_n;
    logic             div_start;
    logic             div_done;
    logic [Q_W-1:0]   div_quot;
    logic [WIDE_W-1:0] shifted;
    logic [OUT_W-1:0] shift_score;
    logic [OUT_W-1:0] exact_score;

    softnorm_regfile #(.DEPTH(NCLS), .W(MAG_W), .AW(CNT_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(st_q.cnt),
        .wdata(wr_val), .raddr(st_q.idx), .rdata(rd_num)
    );

    softnorm_nearp2 #(.DEN_W(DEN_W), .SH_W(SH_W)) u_np2 (
        .den(st_q.den), .sh_n(sh_n)
    );

    softnorm_rdiv #(.NUM_W(MAG_W), .DEN_W(DEN_W), .Q_W(Q_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(rd_num),
        .den(st_q.den), .done(div_done), .quot(div_quot)
    );

    always_comb begin
        wr_val      = in_exp[EXP_W-1] ? '0 : in_exp[MAG_W-1:0];
        shifted     = {rd_num, {OUT_W{1'b0}}} >> sh_n;
        shift_score = (shifted >> OUT_W) != '0 ? {OUT_W{1'b1}} : shifted[OUT_W-1:0];
        exact_score = div_quot[OUT_W] ? {OUT_W{1'b1}} : div_quot[OUT_W-1:0];
    end

    always_comb begin
        st_d      = st_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        wr_en     = 1'b0;
        div_start = 1'b0;
        unique case (st_q.phase)
            PH_LOAD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    wr_en    = 1'b1;
                    st_d.den = st_q.den + DEN_W'(wr_val);
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                    if (in_last || st_q.cnt == CNT_W'(NCLS - 1)) begin
                        st_d.total = st_q.cnt + CNT_W'(1);
                        st_d.mode  = div_mode;
                        st_d.idx   = '0;
                        st_d.phase = PH_START;
                    end
                end
            end
            PH_START: begin
                if (st_q.den == '0) begin
                    st_d.score = '0;
                    st_d.phase = PH_SEND;
                end else if (st_q.mode) begin
                    st_d.score = shift_score;
                    st_d.phase = PH_SEND;
                end else begin
                    div_start  = 1'b1;
                    st_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (div_done) begin
                    st_d.score = exact_score;
                    st_d.phase = PH_SEND;
                end
            end
            PH_SEND: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    if (st_q.idx == st_q.total - CNT_W'(1)) begin
                        st_d.phase = PH_LOAD;
                        st_d.cnt   = '0;
                        st_d.den   = '0;
                    end else begin
                        st_d.idx   = st_q.idx + CNT_W'(1);
                        st_d.phase = PH_START;
                    end
                end
            end
            default: st_d.phase = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_score = st_q.score;
    assign out_last  = out_valid && (st_q.idx == st_q.total - CNT_W'(1));

    // R6: input and output phases never overlap
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R7: a stalled score is held unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_score) && $stable(out_last)));

    // R10: accumulation never wraps while a vector is collected
    a_r10_den_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (st_q.den >= $past(st_q.den)));

    // R4: zero denominator yields zero scores
    a_r4_zero_den: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.den == '0) |-> (out_score == '0));

    // R3: chosen power of two brackets the denominator
    a_r3_pow_bracket: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_START && st_q.mode && st_q.den != '0) |->
        (((DEN_W+2)'(1) << sh_n) <= ((DEN_W+2)'(st_q.den) << 1) &&
         ((DEN_W+2)'(st_q.den) < ((DEN_W+2)'(1) << sh_n) * (DEN_W+2)'(2))));

    // R1: the output index stays inside the received count
    a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (st_q.idx < st_q.total));
endmodule

// File: tb/sim_softnorm_seq.sv
module sim_softnorm_seq;
    localparam int NCLS  = 21;
    localparam int EXP_W = 11;
    localparam int OUT_W = 8;
    localparam int SMAX  = (1 << OUT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [EXP_W-1:0] in_exp = '0;
    logic             in_last = 1'b0;
    logic             div_mode = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [OUT_W-1:0] out_score;
    logic             out_last;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [EXP_W-1:0] vin [NCLS];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    softnorm_seq #(.NCLS(NCLS), .EXP_W(EXP_W), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_exp(in_exp), .in_last(in_last), .div_mode(div_mode),
        .out_valid(out_valid), .out_ready(out_ready), .out_score(out_score),
        .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int mag(input logic [EXP_W-1:0] v);
        return v[EXP_W-1] ? 0 : int'(v[EXP_W-2:0]);
    endfunction

    function automatic int ref_score(input int num, input int den, input bit shmode);
        int q;
        int p;
        int n;
        if (den == 0) return 0;
        if (!shmode) begin
            q = (num * (1 << OUT_W)) / den;
        end else begin
            p = 0;
            for (int i = 0; i < 31; i++) if ((den >> i) & 1) p = i;
            n = (p > 0 && ((den >> (p - 1)) & 1)) ? p + 1 : p;
            q = (num * (1 << OUT_W)) >> n;
        end
        return (q > SMAX) ? SMAX : q;
    endfunction

    task automatic run_vec(input int len, input bit shmode, input bit bp,
                           input bit flip, input string tag);
        int den;
        int expv [NCLS];
        int last_seen;
        int held;
        bit hold_pend;
        den = 0;
        for (int i = 0; i < len; i++) den += mag(vin[i]);
        for (int i = 0; i < len; i++) expv[i] = ref_score(mag(vin[i]), den, shmode);
        out_ready = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_exp   = vin[i];
            in_last  = (i == len - 1) && (len < NCLS || i[0]);
            div_mode = shmode;
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        // R6: keep offering junk while scores are sent; it must be ignored
        in_valid = 1'b1;
        in_exp   = 11'h3ff;
        in_last  = 1'b1;
        if (flip) div_mode = ~shmode;
        last_seen = -1;
        hold_pend = 1'b0;
        held      = 0;
        for (int k = 0; k < len; k++) begin
            forever begin
                if (hold_pend) begin
                    chk(out_valid && int'(out_score) == held, "R7 held score", int'(out_score), held);
                    hold_pend = 1'b0;
                end
                if (bp) out_ready = 1'($urandom_range(0, 1));
                if (out_valid) begin
                    chk(!in_ready, "R6 in_ready low while sending", int'(in_ready), 0);
                    if (out_ready) break;
                    hold_pend = 1'b1;
                    held      = int'(out_score);
                end
                @(negedge clk);
            end
            chk(int'(out_score) == expv[k], tag, int'(out_score), expv[k]);
            chk(out_last == (k == len - 1), "R1 out_last position", int'(out_last), int'(k == len - 1));
            if (!bp && last_seen >= 0)
                chk(cyc - last_seen == ((shmode || den == 0) ? 2 : OUT_W + 4),
                    "R8 score spacing", cyc - last_seen, (shmode || den == 0) ? 2 : OUT_W + 4);
            last_seen = cyc;
            @(negedge clk);
        end
        in_valid  = 1'b0;
        in_last   = 1'b0;
        out_ready = 1'b1;
        chk(in_ready && !out_valid, "R1 back to collecting after count", int'(in_ready), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);

        // R2 / R3: one random vector, both modes
        for (int i = 0; i < NCLS; i++) vin[i] = EXP_W'($urandom_range(0, 1023));
        run_vec(NCLS, 1'b0, 1'b0, 1'b0, "R2 exact score");
        run_vec(NCLS, 1'b1, 1'b0, 1'b0, "R3 shift score");

        // R3: denominator exactly 512
        for (int i = 0; i < 4; i++) vin[i] = 11'd128;
        run_vec(4, 1'b1, 1'b0, 1'b0, "R3 power-of-two denominator");
        run_vec(4, 1'b0, 1'b0, 1'b0, "R2 power-of-two denominator");

        // R3: denominator 768, halfway between 512 and 1024
        for (int i = 0; i < 3; i++) vin[i] = 11'd256;
        run_vec(3, 1'b1, 1'b0, 1'b0, "R3 halfway denominator");
        run_vec(3, 1'b0, 1'b0, 1'b0, "R2 halfway denominator");

        // R2 clamp to max fraction, R3 rounding up (den 100 -> 128)
        vin[0] = 11'd100;
        run_vec(1, 1'b0, 1'b0, 1'b0, "R2 single element clamp");
        run_vec(1, 1'b1, 1'b0, 1'b0, "R3 single element round up");

        // R4: zero denominator, including sign-bit inputs
        vin[0] = 11'd0; vin[1] = 11'h400; vin[2] = 11'h7ff;
        run_vec(3, 1'b0, 1'b0, 1'b0, "R4 zero denominator");

        // R1: negative inputs clamp to zero
        vin[0] = 11'h500; vin[1] = 11'd300; vin[2] = 11'h6aa; vin[3] = 11'd50;
        run_vec(4, 1'b0, 1'b0, 1'b0, "R1 sign-bit input stored as zero");

        // R10: full vector of largest inputs
        for (int i = 0; i < NCLS; i++) vin[i] = 11'd1023;
        run_vec(NCLS, 1'b0, 1'b0, 1'b0, "R10 maximum sum exact");
        run_vec(NCLS, 1'b1, 1'b0, 1'b0, "R10 maximum sum shift");

        // R5: mode flipped after close
        for (int i = 0; i < 7; i++) vin[i] = EXP_W'($urandom_range(1, 1023));
        run_vec(7, 1'b0, 1'b0, 1'b1, "R5 mode latched exact");
        run_vec(7, 1'b1, 1'b0, 1'b1, "R5 mode latched shift");

        // R7: random vectors under backpressure
        for (int t = 0; t < 6; t++) begin
            int len;
            len = $urandom_range(1, NCLS);
            for (int i = 0; i < len; i++) vin[i] = EXP_W'($urandom_range(0, 2047));
            run_vec(len, 1'(t & 1), 1'b1, 1'b0, (t & 1) ? "R3 shift backpressure" : "R2 exact backpressure");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #3000000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule